// File: doc/BRIEF.md
# Prefix-Chained Operand Decoder

This block turns a stream of one-byte instructions into decoded instructions with full-width operands. Each byte holds a 4-bit function code in its upper half and a 4-bit data value in its lower half. Two of the sixteen codes are prefix codes. A prefix byte adds its data nibble to an operand register and shifts it up by one nibble. The negative prefix also inverts the register before the shift. A chain of prefixes of any length can therefore build any positive or negative operand of the configured width.

Every other code ends the chain. When such a byte is accepted, the block puts its function code on the output, together with the completed operand (the register with the byte's own data nibble ORed in). The decoded-instruction strobe is high for that cycle only. The operand register then returns to zero. The "operate" code is marked with its own flag, so that a downstream stage can read its operand as an extended operation number. Input bytes arrive with a valid/ready handshake. The output is a strobe and has no backpressure.

Top module: `nibble_chain_decoder`

## Requirements
- R1: Each accepted byte is split into a function code in bits 7:4 and a data nibble in bits 3:0. On a strobe, `dec_func` equals bits 7:4 of the byte accepted in that cycle.
- R2: Every code other than 0x2 and 0x6 is a terminating code. Accepting such a byte raises `dec_valid` in the same cycle, combinationally. When no prefix came before it, `dec_operand` equals the data nibble, zero-extended.
- R3: Code 0x2 is the positive prefix. Accepting it produces no strobe, and the operand register becomes (register OR data) shifted left by 4.
- R4: Code 0x6 is the negative prefix. Accepting it produces no strobe, and the operand register becomes the bitwise complement of (register OR data), shifted left by 4.
- R5: After a terminating byte is accepted, the operand register is zero. The next instruction's operand therefore depends only on its own prefixes and data.
- R6: Prefix chains of any length compose. The byte pair 0x21, 0x41 yields operand 17. A single prefix reaches every operand from -256 to 255. Bits shifted above the operand width are lost.
- R7: `dec_is_opr` is high exactly when a strobed instruction carries code 0xF. Its operand, including any prefix extension, is delivered on `dec_operand`.
- R8: In a cycle with no accepted byte (`in_valid` low), there is no strobe and the operand register keeps its value. A chain interrupted by idle cycles completes unchanged.
- R9: While `rst` is high, `in_ready` is low and nothing is strobed. A synchronous reset clears the operand register and discards any partly built chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte: code in bits 7:4, data in bits 3:0 |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| dec_valid | output | 1 | One-cycle strobe for a decoded instruction |
| dec_func | output | 4 | Function code of the decoded instruction |
| dec_operand | output | 32 | Completed operand |
| dec_is_opr | output | 1 | Decoded instruction is the operate code |

## Verification
A corrupt operand register stays hidden inside the block until the next terminating byte arrives. At that point it shows up on `dec_operand` in the same cycle, so every check samples the operand of the instruction that follows the stimulus. This applies to idle gaps, resets mid-chain and back-to-back instructions. A wrong prefix decode shows up sooner: a prefix byte that raises the strobe, or a terminating byte that does not, is visible in the cycle the byte is accepted. Chains of mixed positive and negative prefixes check the inversion order, because inverting before the OR or after the shift gives different operands.

// File: rtl/nc_pkg.sv
package nc_pkg;

  // Role of a function code within the instruction set
  typedef enum logic [1:0] {
    FC_DIRECT  = 2'd0,
    FC_PFX_POS = 2'd1,
    FC_PFX_NEG = 2'd2,
    FC_OPERATE = 2'd3
  } fclass_e;

  // Default code assignment
  localparam logic [3:0] CODE_PFX_POS = 4'h2;
  localparam logic [3:0] CODE_PFX_NEG = 4'h6;
  localparam logic [3:0] CODE_OPERATE = 4'hF;

  function automatic logic is_terminal(fclass_e c);
    return (c == FC_DIRECT) || (c == FC_OPERATE);
  endfunction

endpackage

// File: rtl/nc_byte_split.sv
module nc_byte_split
  import nc_pkg::*;
#(
  parameter int FN_W   = 4,
  parameter int DATA_W = 4,
  parameter logic [FN_W-1:0] POS_CODE = 4'h2,
  parameter logic [FN_W-1:0] NEG_CODE = 4'h6,
  parameter logic [FN_W-1:0] OPR_CODE = 4'hF,
  localparam int BYTE_W = FN_W + DATA_W
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic [FN_W-1:0]   func_o,
  output logic [DATA_W-1:0] data_o,
  output fclass_e           cls_o
);

  // Code field sits above the data field (R1)
  assign func_o = byte_i[BYTE_W-1:DATA_W];
  assign data_o = byte_i[DATA_W-1:0];

  always_comb begin
    if (func_o == POS_CODE)      cls_o = FC_PFX_POS;
    else if (func_o == NEG_CODE) cls_o = FC_PFX_NEG;
    else if (func_o == OPR_CODE) cls_o = FC_OPERATE;
    else                         cls_o = FC_DIRECT;
  end

endmodule

// File: rtl/nc_operand_reg.sv
module nc_operand_reg
  import nc_pkg::*;
#(
  parameter int OPND_W = 32,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  fclass_e           cls_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [OPND_W-1:0] opreg_o,
  output logic [OPND_W-1:0] folded_o
);

  localparam int PAD_W = OPND_W - DATA_W;

  // Merge a data nibble into the low end of the register
  function automatic logic [OPND_W-1:0] fold_nibble(logic [OPND_W-1:0] r,
                                                    logic [DATA_W-1:0] d);
    return r | {{PAD_W{1'b0}}, d};
  endfunction

  // Move the register up by one nibble
  function automatic logic [OPND_W-1:0] nib_shift(logic [OPND_W-1:0] r);
    return r << DATA_W;
  endfunction

  logic [OPND_W-1:0] opreg_q;
  logic [OPND_W-1:0] opreg_d;

  assign folded_o = fold_nibble(opreg_q, data_i);
  assign opreg_o  = opreg_q;

  always_comb begin
    opreg_d = opreg_q;
    if (take_i) begin
      unique case (cls_i)
        FC_PFX_POS: opreg_d = nib_shift(folded_o);
        FC_PFX_NEG: opreg_d = nib_shift(~folded_o);
        default:    opreg_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) opreg_q <= '0;
    else     opreg_q <= opreg_d;
  end

  // A prefix always leaves the lowest nibble empty
  assert_prefix_low_clear_R3 : assert property (@(posedge clk) disable iff (rst)
    (take_i && !is_terminal(cls_i)) |=> (opreg_q[DATA_W-1:0] == '0));

  // Register untouched while nothing is accepted
  assert_hold_idle_R8 : assert property (@(posedge clk) disable iff (rst)
    !take_i |=> $stable(opreg_q));

endmodule

// File: rtl/nc_emit.sv
module nc_emit
  import nc_pkg::*;
#(
  parameter int OPND_W = 32,
  parameter int FN_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  fclass_e           cls_i,
  input  logic [FN_W-1:0]   func_i,
  input  logic [OPND_W-1:0] folded_i,
  output logic              valid_o,
  output logic [FN_W-1:0]   func_o,
  output logic [OPND_W-1:0] operand_o,
  output logic              is_opr_o
);

  assign valid_o   = take_i && is_terminal(cls_i);
  assign is_opr_o  = take_i && (cls_i == FC_OPERATE);
  assign func_o    = func_i;
  assign operand_o = folded_i;

  // Prefix bytes never strobe
  assert_prefix_silent_R3 : assert property (@(posedge clk) disable iff (rst)
    (take_i && (cls_i == FC_PFX_POS || cls_i == FC_PFX_NEG)) |-> !valid_o);

  // Operate flag only rides on a strobe
  assert_opr_needs_strobe_R7 : assert property (@(posedge clk) disable iff (rst)
    is_opr_o |-> valid_o);

endmodule

// File: rtl/nibble_chain_decoder.sv
module nibble_chain_decoder
  import nc_pkg::*;
#(
  parameter int FN_W   = 4,
  parameter int DATA_W = 4,
  parameter int OPND_W = 32,
  parameter logic [FN_W-1:0] POS_CODE = CODE_PFX_POS,
  parameter logic [FN_W-1:0] NEG_CODE = CODE_PFX_NEG,
  parameter logic [FN_W-1:0] OPR_CODE = CODE_OPERATE,
  localparam int BYTE_W = FN_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              dec_valid,
  output logic [FN_W-1:0]   dec_func,
  output logic [OPND_W-1:0] dec_operand,
  output logic              dec_is_opr
);

  // Named internal events
  logic              take;
  logic [FN_W-1:0]   func_w;
  logic [DATA_W-1:0] data_w;
  fclass_e           cls_w;
  logic [OPND_W-1:0] opreg_w;
  logic [OPND_W-1:0] folded_w;

  assign in_ready = !rst;
  assign take     = in_valid && in_ready;

  nc_byte_split #(
    .FN_W(FN_W), .DATA_W(DATA_W),
    .POS_CODE(POS_CODE), .NEG_CODE(NEG_CODE), .OPR_CODE(OPR_CODE)
  ) u_split (
    .byte_i (in_byte),
    .func_o (func_w),
    .data_o (data_w),
    .cls_o  (cls_w)
  );

  nc_operand_reg #(.OPND_W(OPND_W), .DATA_W(DATA_W)) u_opreg (
    .clk      (clk),
    .rst      (rst),
    .take_i   (take),
    .cls_i    (cls_w),
    .data_i   (data_w),
    .opreg_o  (opreg_w),
    .folded_o (folded_w)
  );

  nc_emit #(.OPND_W(OPND_W), .FN_W(FN_W)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .take_i    (take),
    .cls_i     (cls_w),
    .func_i    (func_w),
    .folded_i  (folded_w),
    .valid_o   (dec_valid),
    .func_o    (dec_func),
    .operand_o (dec_operand),
    .is_opr_o  (dec_is_opr)
  );

  // Strobe empties the operand register
  assert_clear_after_emit_R5 : assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> (opreg_w == '0));

  // No strobe without an accepted byte
  assert_strobe_needs_byte_R8 : assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (in_valid && in_ready));

endmodule

// File: tb/sim_nibble_chain_decoder.sv
`timescale 1ns/1ps
module sim_nibble_chain_decoder;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_ready;
  logic        dec_valid;
  logic [3:0]  dec_func;
  logic [31:0] dec_operand;
  logic        dec_is_opr;

  always #5 clk = ~clk;

  nibble_chain_decoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .dec_valid(dec_valid), .dec_func(dec_func),
    .dec_operand(dec_operand), .dec_is_opr(dec_is_opr)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic [7:0]  b;
    logic        v;
    logic        o;
    logic [31:0] op;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{8'h41, 1'b1, 1'b0, 32'h0000_0001},  // R2 plain
    '{8'h21, 1'b0, 1'b0, 32'h0},          // R3 prefix
    '{8'h41, 1'b1, 1'b0, 32'h0000_0011},  // R6 value 17
    '{8'h6F, 1'b0, 1'b0, 32'h0},          // R4
    '{8'h40, 1'b1, 1'b0, 32'hFFFF_FF00},  // R6 -256
    '{8'h60, 1'b0, 1'b0, 32'h0},
    '{8'h7F, 1'b1, 1'b0, 32'hFFFF_FFFF},  // R6 -1
    '{8'h2F, 1'b0, 1'b0, 32'h0},
    '{8'hDF, 1'b1, 1'b0, 32'h0000_00FF},  // R6 255
    '{8'hF5, 1'b1, 1'b1, 32'h0000_0005},  // R7
    '{8'h21, 1'b0, 1'b0, 32'h0},
    '{8'h22, 1'b0, 1'b0, 32'h0},
    '{8'h23, 1'b0, 1'b0, 32'h0},
    '{8'hF4, 1'b1, 1'b1, 32'h0000_1234},  // R7 extended
    '{8'h03, 1'b1, 1'b0, 32'h0000_0003},  // R5 clean start
    '{8'h61, 1'b0, 1'b0, 32'h0},
    '{8'h60, 1'b0, 1'b0, 32'h0},
    '{8'h45, 1'b1, 1'b0, 32'h0000_01F5},  // R4 double invert
    '{8'h2A, 1'b0, 1'b0, 32'h0},
    '{8'hB7, 1'b1, 1'b0, 32'h0000_00A7}   // R5/R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h2F;
    #1;
  endtask

  task automatic expect_strobe(input string tag, input logic [7:0] b, input logic [31:0] op);
    chk({tag, " valid"}, {31'd0, dec_valid}, 32'd1);
    chk({tag, " func R1"}, {28'd0, dec_func}, {28'd0, b[7:4]});
    chk({tag, " operand"}, dec_operand, op);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog R9 actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b1;
    in_byte = 8'h41;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 ready in reset", {31'd0, in_ready}, 32'd0);
    chk("R9 no strobe in reset", {31'd0, dec_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    #1;
    chk("R9 ready after reset", {31'd0, in_ready}, 32'd1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      send(VEC[i].b);
      chk($sformatf("R2/R3/R4 table[%0d] strobe", i), {31'd0, dec_valid}, {31'd0, VEC[i].v});
      chk($sformatf("R7 table[%0d] opr", i), {31'd0, dec_is_opr}, {31'd0, VEC[i].o});
      if (VEC[i].v) begin
        chk($sformatf("R6 table[%0d] operand", i), dec_operand, VEC[i].op);
        chk($sformatf("R1 table[%0d] func", i), {28'd0, dec_func}, {28'd0, VEC[i].b[7:4]});
      end
    end

    // Idle gap inside a chain
    send(8'h2A);
    for (int k = 0; k < 4; k++) begin
      idle();
      chk("R8 no strobe when idle", {31'd0, dec_valid}, 32'd0);
    end
    send(8'h4B);
    expect_strobe("R8 chain across gap", 8'h4B, 32'h0000_00AB);

    // Reset mid-chain
    send(8'h27);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    send(8'h43);
    expect_strobe("R9 chain discarded", 8'h43, 32'h0000_0003);

    // Full-width chain and overflow
    send(8'h2F);
    for (int k = 1; k <= 7; k++) send({4'h2, k[3:0]});
    send(8'h48);
    expect_strobe("R6 overflow drops top nibble", 8'h48, 32'h1234_5678);

    // Sweep every code with data 9
    for (int c = 0; c < 16; c++) begin
      send({c[3:0], 4'h9});
      if (c == 2 || c == 6) begin
        chk($sformatf("R3/R4 code %0d silent", c), {31'd0, dec_valid}, 32'd0);
        send(8'h00);
        expect_strobe($sformatf("R3/R4 code %0d flush", c), 8'h00,
                      (c == 2) ? 32'h0000_0090 : 32'hFFFF_FF60);
      end else begin
        expect_strobe($sformatf("R2 code %0d", c), {c[3:0], 4'h9}, 32'h0000_0009);
        chk($sformatf("R7 code %0d flag", c), {31'd0, dec_is_opr},
            (c == 15) ? 32'd1 : 32'd0);
      end
    end

    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule